// File: doc/BRIEF.md
# Capture/Compare Channel with Waveform Output

This block is one channel that sits beside a shared 16-bit timebase. The timebase counter, its tick strobe and the channel-0 match strobe come from outside. The channel runs in one of two roles, and a control word chooses the role.

In capture role the channel picks one of four sources: external input A, external input B, a constant low or a constant high. It can pass the chosen source through a synchroniser stage first. When it sees the chosen edge, it copies the timebase value into its data register and raises its flag. A small state machine records whether that value has been read yet. It has two states: RD_DONE (the value was read) and RD_OWED (the value has not been read). A capture moves the machine to RD_OWED. A read strobe with no capture in the same cycle moves it back to RD_DONE. A capture that arrives while the machine is in RD_OWED sets the sticky overflow bit. To trigger a capture from software, select both-edge capture and switch the source between constant low and constant high.

In compare role the channel watches for the timebase value to equal its data register on a tick cycle. When that happens it raises its flag, latches the level of the chosen source, and updates its output pin under one of eight output modes. Four of these modes also respond to the channel-0 match strobe, which is how PWM waveforms are built. All output changes are registered on the clock.

Top module: `ccu_channel`

## Requirements
- R1: After reset the data register, flag, overflow bit, interrupt request, sampled bit and output pin are all 0.
- R2: Control bits [2:1] choose the capture edge: 00 none, 01 rising, 10 falling, 11 both. An edge of the other kind causes no capture.
- R3: Control bits [4:3] choose the source: 00 input A, 01 input B, 10 constant low, 11 constant high. An unselected input has no effect. With both-edge capture, writing 10 and then 11 causes a capture one cycle after the second write.
- R4: In capture role (control bit 0 = 1), the channel captures on the clock edge where the detected edge is present. The timebase value at that edge goes into the data register and the flag is set. The interrupt request equals the flag ANDed with control bit 10.
- R5: A capture while the previous value is still unread sets the overflow bit (control bit 12 on write). A read strobe marks the value as read. The overflow bit stays set until a control write with bit 12 = 0 clears it.
- R6: In compare role (control bit 0 = 0), a tick cycle with timebase equal to the data register sets the flag and latches the source level into the sampled bit. Without a tick, nothing happens.
- R7: Control bit 5 adds one synchroniser stage, which delays the capture by exactly one clock.
- R8: Control bits [8:6] choose the output mode. Mode 0 copies control bit 9 to the pin one clock after the write. Mode 1 sets the pin on a match. Mode 4 toggles the pin on a match. Mode 5 clears the pin on a match.
- R9: Mode 2 toggles on a match and clears on a channel-0 match. Mode 3 sets on a match and clears on a channel-0 match. Mode 6 toggles on a match and sets on a channel-0 match. Mode 7 clears on a match and sets on a channel-0 match. When both matches occur in the same cycle, the channel-0 action wins.
- R10: A control write loads the flag from bit 11. A data write loads the data register. A capture in the same cycle takes priority over either write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tb_count | input | 16 | Timebase counter value |
| tb_tick | input | 1 | Timebase count-enable strobe |
| eq0_strobe | input | 1 | Channel-0 match strobe |
| cap_in_a | input | 1 | External source A |
| cap_in_b | input | 1 | External source B |
| ctl_we | input | 1 | Control word write |
| ccr_we | input | 1 | Data register write |
| ccr_rd | input | 1 | Data register read strobe |
| bus_wdata | input | 16 | Write data |
| ccr_value | output | 16 | Data register |
| ccif | output | 1 | Channel flag |
| cov | output | 1 | Capture overflow bit |
| irq | output | 1 | Interrupt request |
| smp_in | output | 1 | Sampled source level |
| out_pin | output | 1 | Waveform output |

## Verification
The assertions assume that the tick, the channel-0 strobe and the timebase value are synchronous to the clock. The timebase value must hold steady around each rising edge, and the channel-0 strobe lasts exactly one cycle. The stimulus changes every input only on falling edges. It raises the channel-0 strobe for single cycles. Before changing the source selection it puts the new and old sources at equal levels, so that a switch of source never looks like an edge.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_e;

    typedef enum logic [1:0] {
        SRC_A  = 2'b00,
        SRC_B  = 2'b01,
        SRC_LO = 2'b10,
        SRC_HI = 2'b11
    } insel_e;

    typedef enum logic [2:0] {
        OM_BIT     = 3'd0,
        OM_SET     = 3'd1,
        OM_TGL_RST = 3'd2,
        OM_SET_RST = 3'd3,
        OM_TGL     = 3'd4,
        OM_RST     = 3'd5,
        OM_TGL_SET = 3'd6,
        OM_RST_SET = 3'd7
    } omode_e;

    // Control word layout, LSB at the bottom of the list
    typedef struct packed {
        logic   irq_en;    // [10]
        logic   out_bit;   // [9]
        omode_e omode;     // [8:6]
        logic   sync_en;   // [5]
        insel_e insel;     // [4:3]
        edge_e  edge_sel;  // [2:1]
        logic   cap_mode;  // [0]
    } ctl_t;

    typedef enum logic {
        RD_DONE = 1'b0,
        RD_OWED = 1'b1
    } rdst_e;

    localparam int CTL_BITS = $bits(ctl_t);
    localparam int FLAG_POS = 11;
    localparam int COV_POS  = 12;

endpackage

// File: rtl/ccu_insel.sv
module ccu_insel
    import ccu_pkg::*;
#(
    parameter int STAGES = 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   src_a,
    input  logic   src_b,
    input  insel_e sel,
    input  logic   sync_en,
    input  edge_e  edge_sel,
    output logic   level,
    output logic   hit
);

    logic              raw;
    logic              prev_q;
    logic [STAGES-1:0] chain_q;
    logic              rise, fall;

    always_comb begin
        unique case (sel)
            SRC_A:  raw = src_a;
            SRC_B:  raw = src_b;
            SRC_LO: raw = 1'b0;
            SRC_HI: raw = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= raw;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[g] <= 1'b0;
            else        chain_q[g] <= chain_q[g-1];
        end
    end

    assign level = sync_en ? chain_q[STAGES-1] : raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;
    assign fall = ~level & prev_q;

    always_comb begin
        unique case (edge_sel)
            EDGE_NONE: hit = 1'b0;
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_BOTH: hit = rise | fall;
        endcase
    end

    // R2: a falling-only selection never fires while the level sits high
    p_fall_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel == EDGE_FALL && level) |-> !hit);

endmodule

// File: rtl/ccu_pending.sv
module ccu_pending
    import ccu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cap,
    input  logic rd,
    input  logic clr_we,
    input  logic clr_val,
    output logic cov
);

    rdst_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_DONE: if (cap) state_d = RD_OWED;
            RD_OWED: if (!cap && rd) state_d = RD_DONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_DONE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        cov <= 1'b0;
        else if (cap && state_q == RD_OWED) cov <= 1'b1;
        else if (clr_we && !clr_val)       cov <= 1'b0;
    end

    p_cov_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && state_q == RD_OWED) |=> cov);

    p_cov_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cov && !clr_we) |=> cov);

    p_no_cov_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RD_DONE && !cov && !cap) |=> !cov);

endmodule

// File: rtl/ccu_outunit.sv
module ccu_outunit
    import ccu_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  omode_e mode,
    input  logic   out_bit,
    input  logic   eq,
    input  logic   eq0,
    output logic   out_q
);

    logic nxt;

    always_comb begin
        nxt = out_q;
        unique case (mode)
            OM_BIT:     nxt = out_bit;
            OM_SET:     if (eq) nxt = 1'b1;
            OM_TGL_RST: if (eq0) nxt = 1'b0; else if (eq) nxt = ~out_q;
            OM_SET_RST: if (eq0) nxt = 1'b0; else if (eq) nxt = 1'b1;
            OM_TGL:     if (eq) nxt = ~out_q;
            OM_RST:     if (eq) nxt = 1'b0;
            OM_TGL_SET: if (eq0) nxt = 1'b1; else if (eq) nxt = ~out_q;
            OM_RST_SET: if (eq0) nxt = 1'b1; else if (eq) nxt = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= nxt;
    end

    p_set_on_eq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OM_SET && eq) |=> out_q);

    p_reset_on_eq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == OM_RST && eq) |=> !out_q);

    p_eq0_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == OM_TGL_SET || mode == OM_RST_SET) && eq0) |=> out_q);

    p_eq0_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == OM_TGL_RST || mode == OM_SET_RST) && eq0) |=> !out_q);

endmodule

// File: rtl/ccu_channel.sv
module ccu_channel
    import ccu_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] tb_count,
    input  logic         tb_tick,
    input  logic         eq0_strobe,
    input  logic         cap_in_a,
    input  logic         cap_in_b,
    input  logic         ctl_we,
    input  logic         ccr_we,
    input  logic         ccr_rd,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] ccr_value,
    output logic         ccif,
    output logic         cov,
    output logic         irq,
    output logic         smp_in,
    output logic         out_pin
);

    ctl_t         ctl_q;
    logic [W-1:0] ccr_q;
    logic         flag_q, smp_q;
    logic         level, hit, capture, eq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_we) ctl_q <= ctl_t'(bus_wdata[CTL_BITS-1:0]);
    end

    ccu_insel #(.STAGES(SYNC_STAGES)) u_insel (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_a    (cap_in_a),
        .src_b    (cap_in_b),
        .sel      (ctl_q.insel),
        .sync_en  (ctl_q.sync_en),
        .edge_sel (ctl_q.edge_sel),
        .level    (level),
        .hit      (hit)
    );

    assign capture = ctl_q.cap_mode && hit;
    assign eq      = !ctl_q.cap_mode && tb_tick && (tb_count == ccr_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ccr_q <= '0;
        else if (capture) ccr_q <= tb_count;
        else if (ccr_we)  ccr_q <= bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              flag_q <= 1'b0;
        else if (capture || eq)  flag_q <= 1'b1;
        else if (ctl_we)         flag_q <= bus_wdata[FLAG_POS];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  smp_q <= 1'b0;
        else if (eq) smp_q <= level;
    end

    ccu_pending u_pending (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (capture),
        .rd      (ccr_rd),
        .clr_we  (ctl_we),
        .clr_val (bus_wdata[COV_POS]),
        .cov     (cov)
    );

    ccu_outunit u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (ctl_q.omode),
        .out_bit (ctl_q.out_bit),
        .eq      (eq),
        .eq0     (eq0_strobe),
        .out_q   (out_pin)
    );

    assign ccr_value = ccr_q;
    assign ccif      = flag_q;
    assign smp_in    = smp_q;
    assign irq       = flag_q & ctl_q.irq_en;

    p_capture_stamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (ccr_q == $past(tb_count)) && flag_q);

    p_compare_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eq |=> flag_q && (smp_q == $past(level)));

    p_capture_beats_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && ccr_we) |=> ccr_q == $past(tb_count));

endmodule

// File: tb/sim_ccu_channel.sv
`timescale 1ns/1ps
module sim_ccu_channel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tb_count = '0;
    logic        tb_tick = 1'b0, eq0_strobe = 1'b0;
    logic        cap_in_a = 1'b0, cap_in_b = 1'b0;
    logic        ctl_we = 1'b0, ccr_we = 1'b0, ccr_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] ccr_value;
    logic        ccif, cov, irq, smp_in, out_pin;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    ccu_channel u0 (
        .clk(clk), .rst_n(rst_n), .tb_count(tb_count), .tb_tick(tb_tick),
        .eq0_strobe(eq0_strobe), .cap_in_a(cap_in_a), .cap_in_b(cap_in_b),
        .ctl_we(ctl_we), .ccr_we(ccr_we), .ccr_rd(ccr_rd), .bus_wdata(bus_wdata),
        .ccr_value(ccr_value), .ccif(ccif), .cov(cov), .irq(irq),
        .smp_in(smp_in), .out_pin(out_pin)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mkctl(input logic capm, input logic [1:0] es,
            input logic [1:0] sel, input logic sy, input logic [2:0] om,
            input logic ob, input logic ie, input logic keep_cov);
        logic [15:0] v;
        v = '0;
        v[0] = capm; v[2:1] = es; v[4:3] = sel; v[5] = sy;
        v[8:6] = om; v[9] = ob; v[10] = ie; v[12] = keep_cov;
        return v;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [15:0] v);
        ctl_we = 1'b1; bus_wdata = v; step(); ctl_we = 1'b0;
    endtask

    task automatic wr_ccr(input logic [15:0] v);
        ccr_we = 1'b1; bus_wdata = v; step(); ccr_we = 1'b0;
    endtask

    task automatic rd();
        ccr_rd = 1'b1; step(); ccr_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 ccr", ccr_value, 0);
        chk("R1 flag", 16'(ccif), 0);
        chk("R1 cov", 16'(cov), 0);
        chk("R1 irq", 16'(irq), 0);
        chk("R1 smp", 16'(smp_in), 0);
        chk("R1 out", 16'(out_pin), 0);
    endtask

    task automatic t_edges();
        tb_count = 100;
        wr_ctl(mkctl(1, 2'b01, 2'b00, 0, 0, 0, 1, 1));
        step();
        cap_in_a = 1; tb_count = 123; step();
        chk("R4 stamp", ccr_value, 123);
        chk("R4 flag", 16'(ccif), 1);
        chk("R4 irq on", 16'(irq), 1);
        rd();
        cap_in_a = 0; tb_count = 200; step();
        chk("R2 fall ignored in rise mode", ccr_value, 123);
        wr_ctl(mkctl(1, 2'b10, 2'b00, 0, 0, 0, 0, 1));
        chk("R10 ctl write clears flag", 16'(ccif), 0);
        cap_in_a = 1; tb_count = 300; step();
        chk("R2 rise ignored in fall mode", ccr_value, 123);
        cap_in_a = 0; tb_count = 310; step();
        chk("R2 fall capture", ccr_value, 310);
        chk("R4 irq masked", 16'(irq), 0);
        chk("R5 read clears pending", 16'(cov), 0);
        rd();
        wr_ctl(mkctl(1, 2'b11, 2'b00, 0, 0, 0, 0, 1));
        cap_in_a = 1; tb_count = 400; step();
        chk("R2 both rise", ccr_value, 400);
        rd();
        cap_in_a = 0; tb_count = 410; step();
        chk("R2 both fall", ccr_value, 410);
        rd();
    endtask

    task automatic t_overflow();
        cap_in_a = 1; tb_count = 500; step();
        chk("R5 first capture no cov", 16'(cov), 0);
        cap_in_a = 0; tb_count = 520; step();
        chk("R5 unread recapture", 16'(cov), 1);
        chk("R5 value", ccr_value, 520);
        wr_ctl(mkctl(1, 2'b11, 2'b00, 0, 0, 0, 0, 1));
        chk("R5 write 1 keeps cov", 16'(cov), 1);
        wr_ctl(mkctl(1, 2'b11, 2'b00, 0, 0, 0, 0, 0));
        chk("R5 write 0 clears cov", 16'(cov), 0);
        rd();
        cap_in_a = 1; tb_count = 530; step();
        chk("R5 read then capture", 16'(cov), 0);
        rd();
        cap_in_a = 0; tb_count = 540; step();
        rd();
    endtask

    task automatic t_insel();
        wr_ctl(mkctl(1, 2'b11, 2'b01, 0, 0, 0, 0, 1));
        step();
        cap_in_a = 1; tb_count = 600; step();
        chk("R3 unselected A ignored", ccr_value, 540);
        cap_in_b = 1; tb_count = 610; step();
        chk("R3 input B capture", ccr_value, 610);
        rd();
        cap_in_b = 0; tb_count = 620; step();
        rd();
        cap_in_a = 0;
        wr_ctl(mkctl(1, 2'b11, 2'b10, 0, 0, 0, 0, 1));
        step();
        tb_count = 640;
        wr_ctl(mkctl(1, 2'b11, 2'b11, 0, 0, 0, 0, 1));
        chk("R3 no capture on write edge", ccr_value, 620);
        step();
        chk("R3 software capture high", ccr_value, 640);
        chk("R3 software capture flag", 16'(ccif), 1);
        rd();
        tb_count = 650;
        wr_ctl(mkctl(1, 2'b11, 2'b10, 0, 0, 0, 0, 1));
        step();
        chk("R3 software capture low", ccr_value, 650);
        rd();
    endtask

    task automatic t_sync();
        wr_ctl(mkctl(1, 2'b01, 2'b01, 1, 0, 0, 0, 1));
        step();
        cap_in_b = 1; tb_count = 700; step();
        chk("R7 no capture before sync", ccr_value, 650);
        tb_count = 701; step();
        chk("R7 capture one clock later", ccr_value, 701);
        rd();
        cap_in_b = 0; step();
    endtask

    task automatic t_compare();
        tb_count = 49; tb_tick = 1;
        wr_ctl(mkctl(0, 2'b00, 2'b00, 0, 3'd4, 0, 1, 1));
        wr_ccr(50);
        step();
        chk("R6 no match", 16'(ccif), 0);
        cap_in_a = 1; tb_count = 50; step();
        chk("R6 match flag", 16'(ccif), 1);
        chk("R6 sampled high", 16'(smp_in), 1);
        chk("R8 toggle up", 16'(out_pin), 1);
        cap_in_a = 0; tb_count = 51;
        wr_ctl(mkctl(0, 2'b00, 2'b00, 0, 3'd4, 0, 1, 1));
        tb_count = 50; tb_tick = 0; step();
        chk("R6 no tick no flag", 16'(ccif), 0);
        chk("R6 no tick out held", 16'(out_pin), 1);
        tb_tick = 1; step();
        chk("R6 sampled low", 16'(smp_in), 0);
        chk("R8 toggle down", 16'(out_pin), 0);
        tb_count = 0;
    endtask

    task automatic t_single_modes();
        wr_ctl(mkctl(0, 0, 0, 0, 3'd0, 1, 0, 1));
        chk("R8 mode0 not yet", 16'(out_pin), 0);
        step();
        chk("R8 mode0 high", 16'(out_pin), 1);
        wr_ctl(mkctl(0, 0, 0, 0, 3'd0, 0, 0, 1));
        step();
        chk("R8 mode0 low", 16'(out_pin), 0);
        wr_ctl(mkctl(0, 0, 0, 0, 3'd1, 0, 0, 1));
        step();
        chk("R8 set holds w/o match", 16'(out_pin), 0);
        tb_count = 50; step(); tb_count = 0;
        chk("R8 set on match", 16'(out_pin), 1);
        wr_ctl(mkctl(0, 0, 0, 0, 3'd5, 0, 0, 1));
        tb_count = 50; step(); tb_count = 0;
        chk("R8 reset on match", 16'(out_pin), 0);
    endtask

    task automatic pulse(input logic m, input logic z, input string req, input logic exp);
        tb_count = m ? 16'd50 : 16'd0; eq0_strobe = z; step();
        tb_count = 0; eq0_strobe = 0;
        chk(req, 16'(out_pin), 16'(exp));
    endtask

    task automatic t_pair_modes();
        wr_ctl(mkctl(0, 0, 0, 0, 3'd7, 0, 0, 1));
        pulse(0, 1, "R9 m7 eq0 sets", 1);
        pulse(1, 0, "R9 m7 eq clears", 0);
        pulse(1, 1, "R9 m7 eq0 priority", 1);
        wr_ctl(mkctl(0, 0, 0, 0, 3'd3, 0, 0, 1));
        pulse(0, 1, "R9 m3 eq0 clears", 0);
        pulse(1, 0, "R9 m3 eq sets", 1);
        pulse(1, 1, "R9 m3 eq0 priority", 0);
        wr_ctl(mkctl(0, 0, 0, 0, 3'd6, 0, 0, 1));
        pulse(1, 0, "R9 m6 toggle up", 1);
        pulse(1, 0, "R9 m6 toggle down", 0);
        pulse(1, 1, "R9 m6 eq0 priority", 1);
        wr_ctl(mkctl(0, 0, 0, 0, 3'd2, 0, 0, 1));
        pulse(1, 0, "R9 m2 toggle down", 0);
        pulse(1, 0, "R9 m2 toggle up", 1);
        pulse(1, 1, "R9 m2 eq0 priority", 0);
    endtask

    task automatic t_writes();
        wr_ccr(1234);
        chk("R10 data write", ccr_value, 1234);
        cap_in_a = 0;
        wr_ctl(mkctl(1, 2'b01, 2'b00, 0, 0, 0, 0, 1));
        step();
        cap_in_a = 1; tb_count = 777; ccr_we = 1; bus_wdata = 999; step();
        ccr_we = 0;
        chk("R10 capture beats write", ccr_value, 777);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1;
        t_reset();
        t_edges();
        t_overflow();
        t_insel();
        t_sync();
        t_compare();
        t_single_modes();
        t_pair_modes();
        t_writes();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule